// File: doc/BRIEF.md
# Serial Channel DMA Request Generator

This block produces the DMA request lines for a serial controller with two or more channels. Each channel has two requests. The transmit request asks a DMA engine for the next byte while the transmit buffer is empty. The receive request asks it to collect a byte once the receiver holds a character. A data write to a channel withdraws its transmit request, and a data read withdraws its receive request.

A per-channel arm bit decides whether the transmit request may rise straight after reset, or only once software or DMA has written the first byte. The last channel has no dedicated request pins. Its two requests share a pair of pins with the data-terminal-ready modem outputs, and a two-bit pin mode field picks which function the pins carry.

Every output is registered. An input applied before a clock edge shows on the outputs right after that edge.

Top module: `sio_dmareq`

## Requirements
- R1: While `rst` is high at a clock edge, every request output and both shared pins are low after that edge, and every channel's written-once flag is cleared.
- R2: A one-cycle `rxAvail` pulse on a channel with no read in the same cycle raises that channel's receive request after the edge. The request then stays high for any number of idle cycles.
- R3: `rxRead` on a channel clears its receive request after the edge. If `rxRead` and `rxAvail` arrive together, the read wins and the request is low.
- R4: `txWrite` on a channel clears its transmit request after the edge, even if `txEmpty` is high in the same cycle.
- R5: With the channel's `armMode` bit at 0, `txEmpty` does not raise the transmit request until at least one `txWrite` has occurred on that channel since reset. After that write, `txEmpty` raises the request.
- R6: With the channel's `armMode` bit at 1, `txEmpty` without a write raises the transmit request after the edge. This includes the first edge after reset.
- R7: Once high, a transmit request stays high after `txEmpty` falls, until a write or a reset.
- R8: When `pinMode` is 2'b00, 2'b01 or the reserved 2'b11, the shared pins are modem outputs. `sharedPin[0]` is the inverse of `dtrCtl[0]`, and `sharedPin[1]` is the inverse of `dtrCtl[1]`. A control bit of 1 drives its pin low, and each pin follows its bit one edge later.
- R9: When `pinMode` is 2'b10, `sharedPin[0]` carries the last channel's transmit request and `sharedPin[1]` carries its receive request. They follow R2 to R7 with the same timing as the dedicated requests.
- R10: The written-once flags are kept per channel. A write on one channel does not arm another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txEmpty | input | CH_COUNT | Transmit buffer empty status, one bit per channel |
| txWrite | input | CH_COUNT | Transmit data write strobe, one bit per channel |
| rxAvail | input | CH_COUNT | Received character available strobe, one bit per channel |
| rxRead | input | CH_COUNT | Receive data read strobe, one bit per channel |
| armMode | input | CH_COUNT | 1: transmit request allowed before the first write |
| pinMode | input | 2 | Shared pin function; 2'b10 selects DMA requests |
| dtrCtl | input | 2 | Modem control bits for the two shared pins |
| txReqDir | output | CH_COUNT-1 | Transmit requests of channels with dedicated pins |
| rxReqDir | output | CH_COUNT-1 | Receive requests of channels with dedicated pins |
| sharedPin | output | 2 | Bit 0: ready/transmit request, bit 1: ready/receive request of last channel |

## Verification
The bench builds the block with its default of two channels. Channel 0 then uses the dedicated request pins and channel 1 reaches the outputs only through the shared pins. This setting lets one stimulus stream check the per-channel independence of the arm and written-once logic by looking at both output paths. It also sweeps all four pin mode codes while a hidden request on channel 1 is held, so the bench can confirm that the pins switch function without disturbing that request.

// File: rtl/sio_dmareq_pkg.sv
package sio_dmareq_pkg;

  localparam int PIN_MODE_W = 2;
  localparam logic [PIN_MODE_W-1:0] PIN_MODE_DMA = 2'b10;

  // Per-channel commands from control to datapath
  typedef struct packed {
    logic txSet;
    logic txClr;
    logic rxSet;
    logic rxClr;
  } reqStrobe_t;

endpackage

// File: rtl/sio_dmareq_ctrl.sv
module sio_dmareq_ctrl
  import sio_dmareq_pkg::*;
#(
  parameter int CH_COUNT = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [CH_COUNT-1:0]            txEmpty,
  input  logic [CH_COUNT-1:0]            txWrite,
  input  logic [CH_COUNT-1:0]            rxAvail,
  input  logic [CH_COUNT-1:0]            rxRead,
  input  logic [CH_COUNT-1:0]            armMode,
  output reqStrobe_t [CH_COUNT-1:0]      strb
);

  logic [CH_COUNT-1:0] seenWrite;

  always_ff @(posedge clk) begin
    if (rst) seenWrite <= '0;
    else     seenWrite <= seenWrite | txWrite;
  end

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_ch
    // a write outranks a same-cycle empty report
    assign strb[ch].txClr = txWrite[ch];
    assign strb[ch].txSet = txEmpty[ch] & (armMode[ch] | seenWrite[ch]) & ~txWrite[ch];
    // a read outranks a same-cycle character report
    assign strb[ch].rxClr = rxRead[ch];
    assign strb[ch].rxSet = rxAvail[ch] & ~rxRead[ch];
  end

endmodule

// File: rtl/sio_dmareq_dp.sv
module sio_dmareq_dp
  import sio_dmareq_pkg::*;
#(
  parameter int CH_COUNT = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  reqStrobe_t [CH_COUNT-1:0]  strb,
  input  logic [PIN_MODE_W-1:0]      pinMode,
  input  logic [1:0]                 dtrCtl,
  output logic [CH_COUNT-2:0]        txReqDir,
  output logic [CH_COUNT-2:0]        rxReqDir,
  output logic [1:0]                 sharedPin
);

  localparam int LAST = CH_COUNT - 1;

  logic [CH_COUNT-1:0] txReq, rxReq, txNext, rxNext;
  logic [1:0]          pinNext;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_req
    always_comb begin
      txNext[ch] = txReq[ch];
      if (strb[ch].txClr)      txNext[ch] = 1'b0;
      else if (strb[ch].txSet) txNext[ch] = 1'b1;
      rxNext[ch] = rxReq[ch];
      if (strb[ch].rxClr)      rxNext[ch] = 1'b0;
      else if (strb[ch].rxSet) rxNext[ch] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txReq <= '0;
      rxReq <= '0;
    end else begin
      txReq <= txNext;
      rxReq <= rxNext;
    end
  end

  always_comb begin
    if (pinMode == PIN_MODE_DMA) pinNext = {rxNext[LAST], txNext[LAST]};
    else                         pinNext = ~dtrCtl;
  end

  always_ff @(posedge clk) begin
    if (rst) sharedPin <= '0;
    else     sharedPin <= pinNext;
  end

  assign txReqDir = txReq[CH_COUNT-2:0];
  assign rxReqDir = rxReq[CH_COUNT-2:0];

endmodule

// File: rtl/sio_dmareq.sv
module sio_dmareq
  import sio_dmareq_pkg::*;
#(
  parameter int CH_COUNT = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CH_COUNT-1:0]   txEmpty,
  input  logic [CH_COUNT-1:0]   txWrite,
  input  logic [CH_COUNT-1:0]   rxAvail,
  input  logic [CH_COUNT-1:0]   rxRead,
  input  logic [CH_COUNT-1:0]   armMode,
  input  logic [PIN_MODE_W-1:0] pinMode,
  input  logic [1:0]            dtrCtl,
  output logic [CH_COUNT-2:0]   txReqDir,
  output logic [CH_COUNT-2:0]   rxReqDir,
  output logic [1:0]            sharedPin
);

  reqStrobe_t [CH_COUNT-1:0] strb;

  sio_dmareq_ctrl #(.CH_COUNT(CH_COUNT)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .txEmpty (txEmpty),
    .txWrite (txWrite),
    .rxAvail (rxAvail),
    .rxRead  (rxRead),
    .armMode (armMode),
    .strb    (strb)
  );

  sio_dmareq_dp #(.CH_COUNT(CH_COUNT)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .pinMode   (pinMode),
    .dtrCtl    (dtrCtl),
    .txReqDir  (txReqDir),
    .rxReqDir  (rxReqDir),
    .sharedPin (sharedPin)
  );

endmodule

// File: rtl/sio_dmareq_chk.sv
module sio_dmareq_chk
  import sio_dmareq_pkg::*;
#(
  parameter int CH_COUNT = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [CH_COUNT-1:0]   txEmpty,
  input logic [CH_COUNT-1:0]   txWrite,
  input logic [CH_COUNT-1:0]   rxAvail,
  input logic [CH_COUNT-1:0]   rxRead,
  input logic [CH_COUNT-1:0]   armMode,
  input logic [PIN_MODE_W-1:0] pinMode,
  input logic [1:0]            dtrCtl,
  input logic [CH_COUNT-2:0]   txReqDir,
  input logic [CH_COUNT-2:0]   rxReqDir,
  input logic [1:0]            sharedPin
);

  localparam int LAST = CH_COUNT - 1;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (txReqDir == '0 && rxReqDir == '0 && sharedPin == 2'b00));

  // R2
  rx_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (rxAvail[0] && !rxRead[0]) |=> rxReqDir[0]);

  // R3
  rx_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    rxRead[0] |=> !rxReqDir[0]);

  // R4
  tx_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
    txWrite[0] |=> !txReqDir[0]);

  // R6
  tx_armed_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (armMode[0] && txEmpty[0] && !txWrite[0]) |=> txReqDir[0]);

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (txReqDir[0] && !txWrite[0]) |=> txReqDir[0]);

  // R8
  modem_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (pinMode != PIN_MODE_DMA) |=> (sharedPin == ~$past(dtrCtl)));

  // R9
  shared_tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pinMode == PIN_MODE_DMA && txWrite[LAST]) |=> !sharedPin[0]);

  // R9
  shared_rx_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (pinMode == PIN_MODE_DMA && rxAvail[LAST] && !rxRead[LAST]) |=> sharedPin[1]);

endmodule

bind sio_dmareq sio_dmareq_chk #(.CH_COUNT(CH_COUNT)) u_chk (.*);

// File: tb/sio_dmareq_tb.sv
module sio_dmareq_tb;

  localparam int CH_COUNT = 2;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [CH_COUNT-1:0] txEmpty = '0, txWrite = '0, rxAvail = '0, rxRead = '0, armMode = '0;
  logic [1:0]          pinMode = 2'b00, dtrCtl = 2'b00;
  logic [CH_COUNT-2:0] txReqDir, rxReqDir;
  logic [1:0]          sharedPin;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  sio_dmareq #(.CH_COUNT(CH_COUNT)) u_dut (
    .clk(clk), .rst(rst), .txEmpty(txEmpty), .txWrite(txWrite),
    .rxAvail(rxAvail), .rxRead(rxRead), .armMode(armMode),
    .pinMode(pinMode), .dtrCtl(dtrCtl),
    .txReqDir(txReqDir), .rxReqDir(rxReqDir), .sharedPin(sharedPin)
  );

  // bit 0 of each two-bit field is channel 0, bit 1 is channel 1
  // exp = {txReqDir[0], rxReqDir[0], sharedPin[0], sharedPin[1]}
  typedef struct packed {
    logic       rst;
    logic [1:0] txE;
    logic [1:0] txW;
    logic [1:0] rxA;
    logic [1:0] rxR;
    logic [1:0] arm;
    logic [1:0] mode;
    logic [1:0] dtr;
    logic [3:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 4'b0000}, // 0 R1
    '{1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 4'b0000}, // 1 R5 not armed
    '{1'b0, 2'b11, 2'b01, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 4'b0000}, // 2 R4 write wins
    '{1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 4'b1000}, // 3 R5 R10
    '{1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 4'b1000}, // 4 R7 hold
    '{1'b0, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 4'b0000}, // 5 R4 clear
    '{1'b0, 2'b10, 2'b00, 2'b00, 2'b00, 2'b10, 2'b10, 2'b00, 4'b0010}, // 6 R6 R9
    '{1'b0, 2'b10, 2'b00, 2'b11, 2'b00, 2'b10, 2'b10, 2'b00, 4'b0111}, // 7 R2 R9
    '{1'b0, 2'b10, 2'b00, 2'b00, 2'b00, 2'b10, 2'b10, 2'b00, 4'b0111}, // 8 R2 hold
    '{1'b0, 2'b10, 2'b00, 2'b00, 2'b01, 2'b10, 2'b10, 2'b00, 4'b0011}, // 9 R3
    '{1'b0, 2'b10, 2'b00, 2'b10, 2'b10, 2'b10, 2'b10, 2'b00, 4'b0010}, // 10 R3 read wins
    '{1'b0, 2'b10, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b01, 4'b0001}, // 11 R8
    '{1'b0, 2'b10, 2'b00, 2'b00, 2'b00, 2'b10, 2'b11, 2'b10, 4'b0010}, // 12 R8 reserved
    '{1'b0, 2'b10, 2'b00, 2'b00, 2'b00, 2'b10, 2'b01, 2'b11, 4'b0000}, // 13 R8
    '{1'b0, 2'b10, 2'b00, 2'b00, 2'b00, 2'b10, 2'b10, 2'b11, 4'b0010}, // 14 R9 kept
    '{1'b0, 2'b10, 2'b10, 2'b00, 2'b00, 2'b10, 2'b10, 2'b11, 4'b0000}, // 15 R4 R9
    '{1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b10, 2'b00, 4'b0000}, // 16 R7
    '{1'b0, 2'b01, 2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b00, 4'b1000}, // 17 R6
    '{1'b1, 2'b01, 2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b00, 4'b0000}, // 18 R1
    '{1'b0, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 4'b0000}  // 19 R1 R5
  };

  function automatic string vecTag(input int idx);
    case (idx)
      0, 18:         return "R1";
      1, 19:         return "R5";
      3:             return "R10";
      2, 5, 15:      return "R4";
      4, 16:         return "R7";
      6, 17:         return "R6";
      7, 8:          return "R2";
      9, 10:         return "R3";
      11, 12, 13:    return "R8";
      default:       return "R9";
    endcase
  endfunction

  task automatic checkOut(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {txReqDir[0], rxReqDir[0], sharedPin[0], sharedPin[1]};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    rst = v.rst; txEmpty = v.txE; txWrite = v.txW; rxAvail = v.rxA;
    rxRead = v.rxR; armMode = v.arm; pinMode = v.mode; dtrCtl = v.dtr;
  endtask

  // apply at negedge, sample one ns after the next rising edge
  task automatic step(input vec_t v, input string tag);
    @(negedge clk);
    drive(v);
    @(posedge clk);
    #1;
    checkOut(v.exp, tag);
  endtask

  initial begin
    for (int i = 0; i < NV; i++) step(VECS[i], vecTag(i));

    // R1: during reset with modem mode and control 0, pins stay low
    step('{1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 4'b0000}, "R1");
    // R8: after release, control 0 drives both pins high
    step('{1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 4'b0011}, "R8");
    // R6: armed channel requests on the first edge after reset
    step('{1'b1, 2'b01, 2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b00, 4'b0000}, "R1");
    step('{1'b0, 2'b01, 2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b00, 4'b1000}, "R6");
    // R2: single pulse, then the request stays up over idle cycles
    step('{1'b0, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b10, 2'b00, 4'b1100}, "R2");
    for (int k = 0; k < 3; k++)
      step('{1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 4'b1100}, "R2");
    // R3 and R4: read and write together drop both requests
    step('{1'b0, 2'b00, 2'b01, 2'b00, 2'b01, 2'b00, 2'b10, 2'b00, 4'b0000}, "R3");
    // R10: channel 0 written, channel 1 unarmed, both empty
    step('{1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 4'b1000}, "R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule